// File: doc/BRIEF.md
# Wake-Up Release Sequencer

This block orders the steps that take a logic region from a suspended, write-locked condition back to normal running. While the wake condition is low it holds everything off: inputs blocked, outputs held in their suspend behaviour, storage write-protected, and the awake status line pulled low. Once the wake condition rises, it first re-opens the inputs after a fixed delay. It then raises the awake status line, either by driving it or by letting it go as an open-drain line. After that it waits until the line reads high.

The awake line may be a wired-AND shared by several devices, so the block never trusts its own drive. Two flops synchronise the sensed level, and both release timers start only from that observed rise. One timer hands the outputs back to the application. A second, later timer lifts the write-protect on storage. An optional one-cycle global set/reset can be issued just before the write-protect is lifted.

Each interval setting is a code `c` that selects `c+1` clock cycles. The recommended codes are 3 for the output release and 4 for the write-protect release, which give 4 and 5 cycles.

Top module: `wake_release_seq`

## Requirements
- R1: After reset, and for as long as `wake_ok_i` is low, `in_en_o`, `out_rel_o`, `we_o` and `gsr_o` are 0, `awake_oe_o` is 1 and `awake_drv_o` is 0, so the awake line is pulled low.
- R2: If `wake_ok_i` is first seen high at clock edge k, `in_en_o` rises at edge k+IN_DLY. Until then `out_rel_o` and `we_o` remain 0, and `out_rel_o` is never high while `in_en_o` is low.
- R3: At the edge where `in_en_o` rises, the awake line is released. With `drive_awake_i`=1 the block sets `awake_oe_o`=1 and `awake_drv_o`=1. With `drive_awake_i`=0 it sets `awake_oe_o`=0 and waits for whatever level an external agent leaves on the line.
- R4: The sensed awake level passes through SYNC_STAGES flops, two by default. If the line first goes high after edge L, the timers start at edge L+1+SYNC_STAGES, which is called edge E. No release happens before E.
- R5: `out_rel_o` rises at edge E+N_out, where N_out = `out_code_i`+1. The code is CW bits wide, so N_out can be any value from 1 to 2^CW cycles (1 to 1024 at the default width).
- R6: `we_o` rises at edge E+N_wp, where N_wp = `wp_code_i`+1, with the same range and encoding as R5. The block returns to normal operation at that edge.
- R7: If N_wp is less than or equal to N_out, the write-protect interval is clamped to N_out+1. As a result, `we_o` always rises at least one cycle after `out_rel_o`.
- R8: With `gsr_en_i`=1, `gsr_o` is high for exactly one cycle: the cycle just before `we_o` rises. With `gsr_en_i`=0, `gsr_o` stays 0 and all state is kept.
- R9: In normal operation, `in_en_o`, `out_rel_o` and `we_o` stay 1 and `gsr_o` stays 0. All counters are cleared, so the next wake sequence follows the same timing.
- R10: If `wake_ok_i` is low at any edge, the outputs at that edge return to the R1 suspended values. This applies in every state, including partway through a sequence and during normal operation.
- R11: A reset at any time returns the block to the R1 values. If `wake_ok_i` is high after the reset ends, the full sequence runs again from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the wake-up timing |
| rst | input | 1 | Synchronous active-high reset, also used as the restart |
| wake_ok_i | input | 1 | Wake condition met (high) or suspend held (low) |
| out_code_i | input | CW | Output-release interval code, cycles = code+1 |
| wp_code_i | input | CW | Write-protect release interval code, cycles = code+1 |
| drive_awake_i | input | 1 | 1: drive awake high; 0: release as open drain |
| gsr_en_i | input | 1 | Issue a global set/reset before write-protect release |
| awake_sense_i | input | 1 | Level read back from the awake line |
| in_en_o | output | 1 | Inputs and interconnect enabled |
| awake_drv_o | output | 1 | Value driven onto the awake line |
| awake_oe_o | output | 1 | Awake line output enable |
| out_rel_o | output | 1 | Outputs handed back to the application |
| gsr_o | output | 1 | One-cycle global set/reset |
| we_o | output | 1 | Storage write enable (write-protect lifted) |

## Verification
The bench builds the block with CW=3, IN_DLY=2 and two synchroniser stages. At that size every pairing of the two interval codes (8 by 8) can be run, in both awake modes and with set/reset on and off. This covers every clamp case where the write-protect setting is at or below the output setting, as well as the largest and smallest intervals. In open-drain mode, the external release of the awake line is moved to land before, on and after the block's own release, which exercises the observed-rise start of both timers. Separate runs drop the wake condition partway through a sequence and apply a reset while waking.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

  typedef enum logic [2:0] {
    ST_SUSP  = 3'd0,
    ST_INDLY = 3'd1,
    ST_AWREL = 3'd2,
    ST_TIME  = 3'd3,
    ST_NORM  = 3'd4
  } wrs_state_e;

  localparam int unsigned DFLT_OUT_CODE = 3;
  localparam int unsigned DFLT_WP_CODE  = 4;

endpackage

// File: rtl/wrs_sync.sv
module wrs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/wrs_clamp.sv
module wrs_clamp #(
  parameter int unsigned CW = 10,
  localparam int unsigned TW = CW + 1
) (
  input  logic [CW-1:0] out_code_i,
  input  logic [CW-1:0] wp_code_i,
  output logic [TW-1:0] out_cyc_o,
  output logic [TW-1:0] wp_cyc_o
);

  logic [TW-1:0] wp_raw;

  always_comb begin
    out_cyc_o = {1'b0, out_code_i} + TW'(1);
    wp_raw    = {1'b0, wp_code_i} + TW'(1);
    if (wp_raw <= out_cyc_o) wp_cyc_o = out_cyc_o + TW'(1);
    else                     wp_cyc_o = wp_raw;
  end

endmodule

// File: rtl/wrs_timer.sv
module wrs_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         start_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_o <= '0;
    else if (start_i) cnt_o <= W'(1);
    else if (inc_i)   cnt_o <= cnt_o + W'(1);
  end

endmodule

// File: rtl/wake_release_seq.sv
module wake_release_seq
  import wrs_pkg::*;
#(
  parameter int unsigned CW          = 10,
  parameter int unsigned IN_DLY      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wake_ok_i,
  input  logic [CW-1:0] out_code_i,
  input  logic [CW-1:0] wp_code_i,
  input  logic          drive_awake_i,
  input  logic          gsr_en_i,
  input  logic          awake_sense_i,
  output logic          in_en_o,
  output logic          awake_drv_o,
  output logic          awake_oe_o,
  output logic          out_rel_o,
  output logic          gsr_o,
  output logic          we_o
);

  localparam int unsigned TW = CW + 1;
  localparam int unsigned DW = $clog2(IN_DLY + 1);
  localparam logic [DW-1:0] IN_DLY_V = DW'(IN_DLY);

  wrs_state_e    state_q;
  logic          awake_sync;
  logic [TW-1:0] out_cyc, wp_cyc;
  logic [DW-1:0] dly_cnt;
  logic [TW-1:0] rel_cnt;
  logic          in_en_q, drv_q, oe_q, out_rel_q, gsr_q, we_q;

  wrs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (awake_sense_i),
    .q_o (awake_sync)
  );

  wrs_clamp #(.CW(CW)) u_clamp (
    .out_code_i (out_code_i),
    .wp_code_i  (wp_code_i),
    .out_cyc_o  (out_cyc),
    .wp_cyc_o   (wp_cyc)
  );

  logic dly_clr, dly_start, dly_inc, dly_done;
  assign dly_done  = (dly_cnt >= IN_DLY_V);
  assign dly_clr   = !wake_ok_i || (state_q != ST_SUSP && state_q != ST_INDLY);
  assign dly_start = (state_q == ST_SUSP);
  assign dly_inc   = (state_q == ST_INDLY) && !dly_done;

  wrs_timer #(.W(DW)) u_in_timer (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (dly_clr),
    .start_i (dly_start),
    .inc_i   (dly_inc),
    .cnt_o   (dly_cnt)
  );

  logic rel_clr, rel_start, rel_inc;
  assign rel_clr   = !wake_ok_i || state_q == ST_SUSP || state_q == ST_NORM
                     || state_q == ST_INDLY;
  assign rel_start = (state_q == ST_AWREL) && awake_sync;
  assign rel_inc   = (state_q == ST_TIME);

  wrs_timer #(.W(TW)) u_rel_timer (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (rel_clr),
    .start_i (rel_start),
    .inc_i   (rel_inc),
    .cnt_o   (rel_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst || !wake_ok_i) begin
      state_q   <= ST_SUSP;
      in_en_q   <= 1'b0;
      oe_q      <= 1'b1;
      drv_q     <= 1'b0;
      out_rel_q <= 1'b0;
      gsr_q     <= 1'b0;
      we_q      <= 1'b0;
    end else begin
      case (state_q)
        ST_SUSP:  state_q <= ST_INDLY;
        ST_INDLY: begin
          if (dly_done) begin
            state_q <= ST_AWREL;
            in_en_q <= 1'b1;
            oe_q    <= drive_awake_i;
            drv_q   <= drive_awake_i;
          end
        end
        ST_AWREL: begin
          if (awake_sync) state_q <= ST_TIME;
        end
        ST_TIME: begin
          if (rel_cnt >= out_cyc) out_rel_q <= 1'b1;
          gsr_q <= gsr_en_i && (rel_cnt == wp_cyc - TW'(1));
          if (rel_cnt >= wp_cyc) begin
            we_q    <= 1'b1;
            gsr_q   <= 1'b0;
            state_q <= ST_NORM;
          end
        end
        ST_NORM:  state_q <= ST_NORM;
        default:  state_q <= ST_SUSP;
      endcase
    end
  end

  assign in_en_o     = in_en_q;
  assign awake_drv_o = drv_q;
  assign awake_oe_o  = oe_q;
  assign out_rel_o   = out_rel_q;
  assign gsr_o       = gsr_q;
  assign we_o        = we_q;

  AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !wake_ok_i |=> (!in_en_q && !out_rel_q && !we_q && !gsr_q && oe_q && !drv_q)); // R10
  AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (rst)
    out_rel_q |-> in_en_q); // R2
  AST_NO_REL_BEFORE_SYNC: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_AWREL) |-> (!out_rel_q && !we_q)); // R4
  AST_CLAMP_ORDER: assert property (@(posedge clk) disable iff (rst)
    wp_cyc > out_cyc); // R7
  AST_WE_AFTER_OUT: assert property (@(posedge clk) disable iff (rst)
    $rose(we_q) |-> $past(out_rel_q)); // R7
  AST_GSR_THEN_WE: assert property (@(posedge clk) disable iff (rst)
    (gsr_q && wake_ok_i) |=> we_q); // R8
  AST_GSR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    gsr_q |=> !gsr_q); // R8
  AST_NORM_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (we_q && wake_ok_i) |=> (we_q && out_rel_q && in_en_q && !gsr_q)); // R9

endmodule

// File: tb/wake_release_seq_test.sv
module wake_release_seq_test;

  localparam int CW    = 3;
  localparam int INDLY = 2;
  localparam int SYNC  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wake_ok = 1'b0;
  logic [CW-1:0] out_code = '0;
  logic [CW-1:0] wp_code = '0;
  logic drive = 1'b0;
  logic gsr_en = 1'b0;
  logic ext_hi = 1'b0;
  logic in_en, drv, oe, out_rel, gsr, we;
  logic line;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;

  assign line = oe ? drv : ext_hi;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wake_release_seq #(.CW(CW), .IN_DLY(INDLY), .SYNC_STAGES(SYNC)) uut (
    .clk           (clk),
    .rst           (rst),
    .wake_ok_i     (wake_ok),
    .out_code_i    (out_code),
    .wp_code_i     (wp_code),
    .drive_awake_i (drive),
    .gsr_en_i      (gsr_en),
    .awake_sense_i (line),
    .in_en_o       (in_en),
    .awake_drv_o   (drv),
    .awake_oe_o    (oe),
    .out_rel_o     (out_rel),
    .gsr_o         (gsr),
    .we_o          (we)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_susp(input string req);
    chk(!in_en && !out_rel && !we && !gsr && oe && !drv, req,
        {in_en, out_rel, we, gsr, oe, drv}, 6'b000010);
  endtask

  task automatic run_case(input int g, input int w, input bit dm, input bit ge, input int ext_dly);
    int c0, t_in, t_line, t_out, t_we, t_gsr, n_gsr, n_out, n_wp, exp_line;
    bit done, early;
    @(negedge clk);
    wake_ok = 1'b0;
    ext_hi  = 1'b0;
    @(negedge clk);
    @(negedge clk); #1;
    chk_susp("R10");
    out_code = CW'(g);
    wp_code  = CW'(w);
    drive    = dm;
    gsr_en   = ge;
    c0 = cyc;
    wake_ok = 1'b1;
    t_in = -1; t_line = -1; t_out = -1; t_we = -1; t_gsr = -1; n_gsr = 0;
    done = 1'b0; early = 1'b0;
    for (int n = 0; n < 80 && !done; n++) begin
      @(negedge clk);
      if (!dm && (cyc - c0) == ext_dly) ext_hi = 1'b1;
      #1;
      if (!in_en && (out_rel || we)) early = 1'b1;
      if (in_en && t_in < 0) t_in = cyc;
      if (line && t_line < 0) t_line = cyc;
      if (out_rel && t_out < 0) t_out = cyc;
      if (gsr) begin n_gsr++; if (t_gsr < 0) t_gsr = cyc; end
      if (we && t_we < 0) begin t_we = cyc; done = 1'b1; end
    end
    n_out = g + 1;
    n_wp  = (w + 1 <= n_out) ? n_out + 1 : w + 1;
    exp_line = c0 + 1 + INDLY;
    if (!dm && c0 + ext_dly > exp_line) exp_line = c0 + ext_dly;
    chk(t_in == c0 + 1 + INDLY, "R2 in_en edge", t_in - c0, 1 + INDLY);
    chk(!early, "R2 order", early, 0);
    chk(t_line == exp_line, "R3 awake line", t_line - c0, exp_line - c0);
    chk(t_out == exp_line + 1 + SYNC + n_out, "R5 R4 out_rel edge",
        t_out - c0, exp_line + 1 + SYNC + n_out - c0);
    if (w + 1 <= n_out)
      chk(t_we == exp_line + 1 + SYNC + n_wp, "R7 clamp we edge",
          t_we - c0, exp_line + 1 + SYNC + n_wp - c0);
    else
      chk(t_we == exp_line + 1 + SYNC + n_wp, "R6 we edge",
          t_we - c0, exp_line + 1 + SYNC + n_wp - c0);
    if (ge)
      chk(n_gsr == 1 && t_gsr == t_we - 1, "R8 gsr pulse", t_gsr - c0, t_we - 1 - c0);
    else
      chk(n_gsr == 0, "R8 gsr off", n_gsr, 0);
    @(negedge clk); #1;
    chk(in_en && out_rel && we && !gsr && (dm ? (oe && drv) : !oe), "R9 normal hold",
        {in_en, out_rel, we, gsr, oe, drv}, dm ? 6'b111011 : 6'b111000);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk_susp("R1");

    for (int g = 0; g < 8; g++)
      for (int w = 0; w < 8; w++)
        for (int m = 0; m < 4; m++)
          run_case(g, w, m[0], m[1], 1 + ((g + w) % 5));

    // R10: drop the wake condition partway through the timers
    @(negedge clk);
    wake_ok = 1'b0;
    ext_hi = 1'b0;
    repeat (2) @(negedge clk);
    out_code = CW'(5);
    wp_code  = CW'(7);
    drive = 1'b1;
    gsr_en = 1'b1;
    wake_ok = 1'b1;
    repeat (1 + INDLY + 1 + SYNC + 3) @(negedge clk);
    #1;
    chk(in_en && !we, "R10 mid-sequence", {in_en, we}, 2'b10);
    wake_ok = 1'b0;
    @(negedge clk); #1;
    chk_susp("R10 abort");

    // R11: restart while waking, then rerun
    wake_ok = 1'b1;
    repeat (1 + INDLY + 2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); #1;
    chk_susp("R11 restart");
    begin
      int r, t;
      bit seen;
      r = cyc;
      rst = 1'b0;
      seen = 1'b0;
      t = -1;
      for (int n = 0; n < 40 && !seen; n++) begin
        @(negedge clk); #1;
        if (in_en) begin seen = 1'b1; t = cyc; end
      end
      chk(t == r + 1 + INDLY, "R11 rerun in_en", t - r, 1 + INDLY);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule